// File: doc/BRIEF.md
# Board Test Mode Controller

This block sets the board-level manufacturing test modes of a peripheral chip. When the power-good input is low, the block disables every output pin through one global output-enable. Two clock outputs are exempt: the 14 MHz output is held low, and the 32 kHz output keeps following its input. This lets a tester drive the board nets without the chip fighting it.

While power-good is low, a tester can also arm a solder-connectivity test. It pulses the active-low test strobe and holds an 8-bit code on the data bus. The block synchronizes the strobe to its clock and samples the bus while the synchronized strobe is low. At the synchronized rising edge it arms the test, but only if the code is 8'hFE. While the test is armed, a dedicated pin carries the AND of all tree input pins. A tester can then find an open or shorted pin by walking a single zero across the inputs.

Power-good and the bus are expected to be quasi-static relative to the clock. The strobe is treated as asynchronous. The block has no streaming data path, so all pins are plain control and status signals.

Top module: `mfg_test_ctrl`

## Requirements
- R1: `out_en` equals `pwr_good` in the same cycle: 0 disables all chip outputs (high-impedance mode) and 1 enables them.
- R2: `clk14_out` is 0 whenever `pwr_good` is 0, and follows `clk14_in` whenever `pwr_good` is 1.
- R3: `clk32_out` follows `clk32_in` at all times, whatever the value of `pwr_good`.
- R4: A rising edge of `test_n` arms the test only if `pwr_good` is 0; a strobe pulse while `pwr_good` is 1 leaves `conn_test_on` at 0.
- R5: The code is the value of `test_data` sampled while the synchronized strobe is low. At the rising edge, `conn_test_on` becomes 1 if the code is 8'hFE and 0 for any other code, so a later pulse with a different code disarms the test.
- R6: On the first clock edge with `pwr_good` at 1, `conn_test_on` and the captured code clear.
- R7: While `conn_test_on` is 1, `tree_out` is the AND of all bits of `tree_in`.
- R8: While `conn_test_on` is 0, `tree_out` is 0.
- R9: After `test_n` rises, `conn_test_on` changes on the third rising clock edge: two synchronizer stages, then the edge register.
- R10: After reset, `conn_test_on` and `tree_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good; low selects high-impedance mode |
| test_n | input | 1 | Asynchronous active-low test strobe |
| test_data | input | 8 | Code bus sampled while the strobe is low |
| clk14_in | input | 1 | 14 MHz clock input |
| clk32_in | input | 1 | 32 kHz clock input |
| tree_in | input | TREE_W | Input pins feeding the AND tree |
| out_en | output | 1 | Global output-enable for the chip's pads |
| clk14_out | output | 1 | 14 MHz output, forced low in high-impedance mode |
| clk32_out | output | 1 | 32 kHz pass-through output |
| conn_test_on | output | 1 | Connectivity test is armed |
| tree_out | output | 1 | AND-tree result, gated by `conn_test_on` |

## Verification
The hardest state to reach is a test that is armed and then has to be disarmed without using power-good. This needs a second strobe pulse, still with power-good low, carrying a code other than 8'hFE. The bench first arms the test with 8'hFE, then sends a pulse with 8'h7E, which differs from 8'hFE in one bit, and checks that the flag drops. It also checks the exact edge on which the flag rises by sampling after the second and third clock edges that follow the strobe's release. With the test armed, it walks a single zero across the tree inputs.

// File: rtl/mfg_test_pkg.sv
package mfg_test_pkg;
  localparam int unsigned CODE_W = 8;
  localparam logic [CODE_W-1:0] ARM_CODE = 8'hFE;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic strobe_low,
  output logic rise_pulse
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= strobe_n;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign strobe_low = ~s2;
  assign rise_pulse = s2 & ~s3;

  // R9: an edge lasts exactly one cycle
  p_edge_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/code_latch.sv
module code_latch
  import mfg_test_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pwr_good,
  input  logic  strobe_low,
  input  logic  rise_pulse,
  input  code_t bus_in,
  output logic  armed
);
  code_t shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      armed  <= 1'b0;
    end else if (pwr_good) begin
      shadow <= '0;
      armed  <= 1'b0;
    end else begin
      if (strobe_low) shadow <= bus_in;
      if (rise_pulse) armed <= (shadow == ARM_CODE);
    end
  end

  // R6: power-good clears the armed flag on the next edge
  p_clear_on_pg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |=> !armed);
  // R4: arming needs a strobe edge seen while power-good was low
  p_arm_needs_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> ($past(rise_pulse) && !$past(pwr_good)));
  // R5: the flag holds unless an edge or power-good occurs
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_pulse && !pwr_good) |=> $stable(armed));
endmodule

// File: rtl/and_tree.sv
module and_tree #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             enable,
  input  logic [WIDTH-1:0] pins,
  output logic             result
);
  logic [WIDTH:0] chain;

  assign chain[0] = 1'b1;
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign chain[i+1] = chain[i] & pins[i];
  end

  assign result = enable & chain[WIDTH];

  // R7: chained result agrees with a full reduction when enabled
  always_comb begin
    if (enable) p_tree_match_r7: assert (result == (&pins));
  end
endmodule

// File: rtl/mfg_test_ctrl.sv
module mfg_test_ctrl
  import mfg_test_pkg::*;
#(
  parameter int unsigned TREE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              test_n,
  input  logic [CODE_W-1:0] test_data,
  input  logic              clk14_in,
  input  logic              clk32_in,
  input  logic [TREE_W-1:0] tree_in,
  output logic              out_en,
  output logic              clk14_out,
  output logic              clk32_out,
  output logic              conn_test_on,
  output logic              tree_out
);
  logic strobe_low, rise_pulse;

  strobe_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_n   (test_n),
    .strobe_low (strobe_low),
    .rise_pulse (rise_pulse)
  );

  code_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .strobe_low (strobe_low),
    .rise_pulse (rise_pulse),
    .bus_in     (test_data),
    .armed      (conn_test_on)
  );

  and_tree #(.WIDTH(TREE_W)) u_tree (
    .enable (conn_test_on),
    .pins   (tree_in),
    .result (tree_out)
  );

  assign out_en    = pwr_good;
  assign clk14_out = pwr_good & clk14_in;
  assign clk32_out = clk32_in;

  // R1/R2: high-impedance mode holds both enable and 14 MHz output low
  p_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |-> (!out_en && !clk14_out));
  // R8: the tree pin stays quiet while the test is not armed
  p_tree_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !conn_test_on |-> !tree_out);
endmodule

// File: tb/mfg_test_ctrl_tb.sv
`timescale 1ns/1ps
module mfg_test_ctrl_tb;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b1;
  logic test_n = 1'b1;
  logic [7:0] test_data = 8'h00;
  logic clk14_in = 1'b0;
  logic clk32_in = 1'b0;
  logic [TW-1:0] tree_in = '1;
  logic out_en, clk14_out, clk32_out, conn_test_on, tree_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mfg_test_ctrl #(.TREE_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .test_n(test_n),
    .test_data(test_data), .clk14_in(clk14_in), .clk32_in(clk32_in),
    .tree_in(tree_in), .out_en(out_en), .clk14_out(clk14_out),
    .clk32_out(clk32_out), .conn_test_on(conn_test_on), .tree_out(tree_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input logic [7:0] code);
    test_data = code;
    test_n = 1'b0;
    cyc(4);
    test_n = 1'b1;
    cyc(5);
  endtask

  task automatic t_reset;
    check("R10 flag after reset", conn_test_on, 1'b0);
    check("R10 tree after reset", tree_out, 1'b0);
  endtask

  task automatic t_hiz;
    pwr_good = 1'b1; clk14_in = 1'b1; #1;
    check("R1 enable high", out_en, 1'b1);
    check("R2 clk14 follows", clk14_out, 1'b1);
    pwr_good = 1'b0; #1;
    check("R1 enable low", out_en, 1'b0);
    check("R2 clk14 forced low", clk14_out, 1'b0);
    clk32_in = 1'b1; #1;
    check("R3 clk32 high in hiz", clk32_out, 1'b1);
    clk32_in = 1'b0; #1;
    check("R3 clk32 low in hiz", clk32_out, 1'b0);
    clk14_in = 1'b0;
    cyc(1);
  endtask

  task automatic t_pulse_pg_high;
    pwr_good = 1'b1; cyc(1);
    strobe(8'hFE);
    check("R4 pulse with pg high ignored", conn_test_on, 1'b0);
  endtask

  task automatic t_latency;
    pwr_good = 1'b0; cyc(1);
    test_data = 8'hFE; test_n = 1'b0;
    cyc(4);
    test_n = 1'b1;
    cyc(2);
    check("R9 not yet after 2 edges", conn_test_on, 1'b0);
    cyc(1);
    check("R9 set on 3rd edge", conn_test_on, 1'b1);
    check("R5 FE arms", conn_test_on, 1'b1);
    cyc(2);
  endtask

  task automatic t_tree;
    tree_in = '1; #1;
    check("R7 all ones", tree_out, 1'b1);
    for (int i = 0; i < TW; i++) begin
      tree_in = ~(TW'(1) << i); #1;
      check("R7 walking zero", tree_out, 1'b0);
    end
    tree_in = '1; cyc(1);
  endtask

  task automatic t_bad_code;
    strobe(8'h7E);
    check("R5 other code disarms", conn_test_on, 1'b0);
    check("R8 tree quiet when off", tree_out, 1'b0);
    strobe(8'hFF);
    check("R5 FF does not arm", conn_test_on, 1'b0);
  endtask

  task automatic t_pg_clear;
    strobe(8'hFE);
    check("R5 re-arm", conn_test_on, 1'b1);
    pwr_good = 1'b1;
    cyc(1);
    check("R6 cleared after pg high", conn_test_on, 1'b0);
    check("R8 tree low after clear", tree_out, 1'b0);
    pwr_good = 1'b0;
    test_n = 1'b0; test_data = 8'h00; cyc(1);
    test_data = 8'hFE; cyc(1);
    test_n = 1'b1; test_data = 8'h00; cyc(5);
    check("R6 no stale code kept", conn_test_on, 1'b0);
    pwr_good = 1'b1; cyc(1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_hiz();
    t_pulse_pg_high();
    t_latency();
    t_tree();
    t_bad_code();
    t_pg_clear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule